// File: doc/BRIEF.md
# Register-Tagged Load Result Cache

This block is a two-entry, load-only cache that sits ahead of the L1 data cache. It is looked up with the operand fields that the load instruction names, not with an address. Those fields are the base register number, an optional index register number with its scale, and a displacement. On a hit, the cached line data comes back in the same cycle. A hit needs no register read, no address generation, no translation lookup and no L1 array access.

A miss goes to the L1 through the normal address path. The returned line is then written in through the fill port, together with the L1 line index it came from. The cache never holds store data.

The entries stay correct through three snoop inputs:

- a register writeback port, which drops every entry whose base or index register is written;
- an L1 eviction port, which drops entries by line index;
- a store-alias port, which drops entries by line index in the same way as an eviction.

A flush input clears every entry at once, for context switches and translation shootdowns.

Top module: `symtag_l0_cache`

## Requirements
- R1: Reset, and a flush asserted in one cycle, leave every entry invalid, so that every lookup in the cycles that follow misses until a new fill is made.
- R2: A lookup hits only when a valid entry has the same base register, index-present flag and displacement. When the index is present, the index register and scale must also match. `lk_data_o` carries that entry's data in the same cycle, and it is all zeros on a miss. At most one entry hits at a time.
- R3: `lk_has_idx_i`/`fl_has_idx_i` = 1 means the load uses an index register. A load without an index never hits an entry filled with one, and the reverse also holds. When the flag is 0, the index and scale fields are ignored: both for matching and for register-write snooping.
- R4: A register writeback whose destination equals a valid entry's base register invalidates that entry, and so does one that equals its index register when the index is present. A lookup in that same cycle already misses on that entry.
- R5: An L1 eviction whose line index equals an entry's stored line index invalidates that entry. A lookup in that same cycle already misses on it.
- R6: A store-alias notice is handled exactly like an eviction. It invalidates by line index, and a lookup in the same cycle misses.
- R7: A fill is dropped in any of these cases: a same-cycle register writeback names its base register, or its index register when the index is present; a same-cycle eviction or store-alias names its line; or a flush is asserted in that cycle.
- R8: An accepted fill with no matching entry goes into the lowest-numbered invalid entry. If both entries are valid, it replaces the least recently used entry. "Used" means the latest accepted fill, or otherwise the latest hit.
- R9: A fill whose symbolic tag matches a valid entry overwrites that entry, so there are never two copies of one tag.
- R10: Filled data becomes visible to lookups from the cycle after the fill. A lookup in the fill cycle itself still misses.
- R11: A lookup in the same cycle as a flush misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_base_i | input | REG_W | Lookup base register number |
| lk_has_idx_i | input | 1 | Lookup uses an index register |
| lk_idx_i | input | REG_W | Lookup index register number |
| lk_scale_i | input | SCALE_W | Lookup index scale code |
| lk_disp_i | input | DISP_W | Lookup displacement |
| lk_hit_o | output | 1 | Lookup hit, same cycle |
| lk_data_o | output | DATA_W | Hit data, zero on miss |
| fl_valid_i | input | 1 | Fill request |
| fl_base_i | input | REG_W | Fill base register number |
| fl_has_idx_i | input | 1 | Fill uses an index register |
| fl_idx_i | input | REG_W | Fill index register number |
| fl_scale_i | input | SCALE_W | Fill index scale code |
| fl_disp_i | input | DISP_W | Fill displacement |
| fl_line_i | input | LINE_W | L1 line index of the fill data |
| fl_data_i | input | DATA_W | Fill data from the L1 |
| rw_valid_i | input | 1 | Register writeback seen |
| rw_reg_i | input | REG_W | Destination register number of the writeback |
| ev_valid_i | input | 1 | L1 eviction seen |
| ev_line_i | input | LINE_W | Evicted L1 line index |
| sa_valid_i | input | 1 | Aliasing store seen |
| sa_line_i | input | LINE_W | L1 line index written by the store |

## Verification
Hit and data are combinational. They are due in the same cycle as the lookup and reflect the entry state left by the previous clock edge together with any invalidation arriving in that cycle.

Fills, snoops and flushes change entry state at the next clock edge, so their effect is due one cycle later. The bench drives each cycle's inputs just after the falling edge and samples the outputs two nanoseconds later. At that point the behavioural model has already applied the preceding rising edge. Same-cycle invalidation and lookups in the fill cycle are therefore compared against the pre-edge state, and follow-up lookups against the post-edge state.

// File: rtl/symtag_l0_pkg.sv
package symtag_l0_pkg;
   localparam int unsigned DEF_ENTRIES = 2;
   localparam int unsigned DEF_REG_W   = 4;
   localparam int unsigned DEF_SCALE_W = 2;
   localparam int unsigned DEF_DISP_W  = 32;
   localparam int unsigned DEF_LINE_W  = 9;
   localparam int unsigned DEF_DATA_W  = 512;

   // reason a fill target was chosen
   typedef enum logic [1:0] {
      VSEL_DUP  = 2'd0,
      VSEL_FREE = 2'd1,
      VSEL_LRU  = 2'd2
   } vsel_e;
endpackage

// File: rtl/symtag_l0_entry.sv
module symtag_l0_entry
   import symtag_l0_pkg::*;
#(
   parameter int unsigned REG_W   = DEF_REG_W,
   parameter int unsigned SCALE_W = DEF_SCALE_W,
   parameter int unsigned DISP_W  = DEF_DISP_W,
   parameter int unsigned LINE_W  = DEF_LINE_W,
   parameter int unsigned DATA_W  = DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              lk_valid_i,
   input  logic [REG_W-1:0]  lk_base_i,
   input  logic              lk_has_idx_i,
   input  logic [REG_W-1:0]  lk_idx_i,
   input  logic [SCALE_W-1:0] lk_scale_i,
   input  logic [DISP_W-1:0] lk_disp_i,
   input  logic              fl_we_i,
   input  logic [REG_W-1:0]  fl_base_i,
   input  logic              fl_has_idx_i,
   input  logic [REG_W-1:0]  fl_idx_i,
   input  logic [SCALE_W-1:0] fl_scale_i,
   input  logic [DISP_W-1:0] fl_disp_i,
   input  logic [LINE_W-1:0] fl_line_i,
   input  logic [DATA_W-1:0] fl_data_i,
   input  logic              rw_valid_i,
   input  logic [REG_W-1:0]  rw_reg_i,
   input  logic              ev_valid_i,
   input  logic [LINE_W-1:0] ev_line_i,
   input  logic              sa_valid_i,
   input  logic [LINE_W-1:0] sa_line_i,
   output logic              valid_o,
   output logic              hit_o,
   output logic              dup_o,
   output logic [DATA_W-1:0] data_o
);

   logic               v_q;
   logic               hx_q;
   logic [REG_W-1:0]   b_q;
   logic [REG_W-1:0]   x_q;
   logic [SCALE_W-1:0] s_q;
   logic [DISP_W-1:0]  d_q;
   logic [LINE_W-1:0]  l_q;
   logic [DATA_W-1:0]  dat_q;

   logic reg_snoop;
   logic line_snoop;
   logic kill;

   function automatic logic sym_eq(
      input logic [REG_W-1:0]   b,
      input logic               hx,
      input logic [REG_W-1:0]   x,
      input logic [SCALE_W-1:0] s,
      input logic [DISP_W-1:0]  d
   );
      sym_eq = (b == b_q) && (hx == hx_q) && (d == d_q) &&
               (!hx || ((x == x_q) && (s == s_q)));
   endfunction

   always_comb begin
      reg_snoop  = rw_valid_i && ((rw_reg_i == b_q) || (hx_q && (rw_reg_i == x_q)));
      line_snoop = (ev_valid_i && (ev_line_i == l_q)) ||
                   (sa_valid_i && (sa_line_i == l_q));
      kill       = flush_i || (v_q && (reg_snoop || line_snoop));
      hit_o      = lk_valid_i && v_q && !kill &&
                   sym_eq(lk_base_i, lk_has_idx_i, lk_idx_i, lk_scale_i, lk_disp_i);
      dup_o      = v_q && sym_eq(fl_base_i, fl_has_idx_i, fl_idx_i, fl_scale_i, fl_disp_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         hx_q  <= 1'b0;
         b_q   <= '0;
         x_q   <= '0;
         s_q   <= '0;
         d_q   <= '0;
         l_q   <= '0;
         dat_q <= '0;
      end else begin
         if (fl_we_i) begin
            v_q   <= 1'b1;
            hx_q  <= fl_has_idx_i;
            b_q   <= fl_base_i;
            x_q   <= fl_idx_i;
            s_q   <= fl_scale_i;
            d_q   <= fl_disp_i;
            l_q   <= fl_line_i;
            dat_q <= fl_data_i;
         end else if (kill) begin
            v_q <= 1'b0;
         end
      end
   end

   assign valid_o = v_q;
   assign data_o  = dat_q;

   // R4
   base_write_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && rw_valid_i && (rw_reg_i == b_q) && !fl_we_i) |=> !v_q);

   // R4
   index_write_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && hx_q && rw_valid_i && (rw_reg_i == x_q) && !fl_we_i) |=> !v_q);

   // R5
   evict_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && ev_valid_i && (ev_line_i == l_q) && !fl_we_i) |=> !v_q);

   // R6
   alias_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && sa_valid_i && (sa_line_i == l_q) && !fl_we_i) |=> !v_q);

   // R10
   fill_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we_i |=> (v_q && (b_q == $past(fl_base_i)) && (l_q == $past(fl_line_i)) &&
                   (dat_q == $past(fl_data_i))));

endmodule

// File: rtl/symtag_l0_victim.sv
module symtag_l0_victim
   import symtag_l0_pkg::*;
#(
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] dup_i,
   input  logic [ENTRIES-1:0] hit_i,
   input  logic               fill_go_i,
   output logic [IDX_W-1:0]   sel_o
);

   logic [IDX_W-1:0] lru_q;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] dup_idx;
   logic [IDX_W-1:0] hit_idx;
   logic             any_free;
   logic             any_dup;
   vsel_e            why;

   always_comb begin
      free_idx = '0;
      dup_idx  = '0;
      hit_idx  = '0;
      any_free = 1'b0;
      any_dup  = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
         if (dup_i[i]) begin
            any_dup = 1'b1;
            dup_idx = IDX_W'(i);
         end
         if (hit_i[i]) hit_idx = IDX_W'(i);
      end
      why = any_dup ? VSEL_DUP : (any_free ? VSEL_FREE : VSEL_LRU);
      case (why)
         VSEL_DUP:  sel_o = dup_idx;
         VSEL_FREE: sel_o = free_idx;
         default:   sel_o = lru_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lru_q <= '0;
      end else if (fill_go_i) begin
         lru_q <= ~sel_o;
      end else if (|hit_i) begin
         lru_q <= ~hit_idx;
      end
   end

   // R8
   free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go_i && !(|dup_i) && !(&valid_i)) |-> !valid_i[sel_o]);

   // R9
   dup_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go_i && (|dup_i)) |-> dup_i[sel_o]);

   // R8
   lru_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go_i |=> (lru_q != $past(sel_o)));

endmodule

// File: rtl/symtag_l0_cache.sv
module symtag_l0_cache
   import symtag_l0_pkg::*;
#(
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   parameter int unsigned REG_W   = DEF_REG_W,
   parameter int unsigned SCALE_W = DEF_SCALE_W,
   parameter int unsigned DISP_W  = DEF_DISP_W,
   parameter int unsigned LINE_W  = DEF_LINE_W,
   parameter int unsigned DATA_W  = DEF_DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic               lk_valid_i,
   input  logic [REG_W-1:0]   lk_base_i,
   input  logic               lk_has_idx_i,
   input  logic [REG_W-1:0]   lk_idx_i,
   input  logic [SCALE_W-1:0] lk_scale_i,
   input  logic [DISP_W-1:0]  lk_disp_i,
   output logic               lk_hit_o,
   output logic [DATA_W-1:0]  lk_data_o,
   input  logic               fl_valid_i,
   input  logic [REG_W-1:0]   fl_base_i,
   input  logic               fl_has_idx_i,
   input  logic [REG_W-1:0]   fl_idx_i,
   input  logic [SCALE_W-1:0] fl_scale_i,
   input  logic [DISP_W-1:0]  fl_disp_i,
   input  logic [LINE_W-1:0]  fl_line_i,
   input  logic [DATA_W-1:0]  fl_data_i,
   input  logic               rw_valid_i,
   input  logic [REG_W-1:0]   rw_reg_i,
   input  logic               ev_valid_i,
   input  logic [LINE_W-1:0]  ev_line_i,
   input  logic               sa_valid_i,
   input  logic [LINE_W-1:0]  sa_line_i
);

   localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES != 2) begin : g_bad_entries
      $error("symtag_l0_cache: ENTRIES must be 2 (single-bit LRU)");
   end
   if (REG_W < 1 || LINE_W < 1 || DATA_W < 1 || DISP_W < 1 || SCALE_W < 1) begin : g_bad_width
      $error("symtag_l0_cache: field widths must be at least 1");
   end

   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_hit;
   logic [ENTRIES-1:0] ent_dup;
   logic [ENTRIES-1:0] ent_we;
   logic [DATA_W-1:0]  ent_data [ENTRIES];
   logic [IDX_W-1:0]   fill_sel;
   logic               fill_reg_snoop;
   logic               fill_line_snoop;
   logic               fill_go;

   always_comb begin
      fill_reg_snoop  = rw_valid_i && ((rw_reg_i == fl_base_i) ||
                                       (fl_has_idx_i && (rw_reg_i == fl_idx_i)));
      fill_line_snoop = (ev_valid_i && (ev_line_i == fl_line_i)) ||
                        (sa_valid_i && (sa_line_i == fl_line_i));
      fill_go         = fl_valid_i && !flush_i && !fill_reg_snoop && !fill_line_snoop;
   end

   symtag_l0_victim #(
      .ENTRIES (ENTRIES)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (ent_valid),
      .dup_i     (ent_dup),
      .hit_i     (ent_hit),
      .fill_go_i (fill_go),
      .sel_o     (fill_sel)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign ent_we[g] = fill_go && (fill_sel == IDX_W'(g));

      symtag_l0_entry #(
         .REG_W   (REG_W),
         .SCALE_W (SCALE_W),
         .DISP_W  (DISP_W),
         .LINE_W  (LINE_W),
         .DATA_W  (DATA_W)
      ) u_ent (
         .clk          (clk),
         .rst_n        (rst_n),
         .flush_i      (flush_i),
         .lk_valid_i   (lk_valid_i),
         .lk_base_i    (lk_base_i),
         .lk_has_idx_i (lk_has_idx_i),
         .lk_idx_i     (lk_idx_i),
         .lk_scale_i   (lk_scale_i),
         .lk_disp_i    (lk_disp_i),
         .fl_we_i      (ent_we[g]),
         .fl_base_i    (fl_base_i),
         .fl_has_idx_i (fl_has_idx_i),
         .fl_idx_i     (fl_idx_i),
         .fl_scale_i   (fl_scale_i),
         .fl_disp_i    (fl_disp_i),
         .fl_line_i    (fl_line_i),
         .fl_data_i    (fl_data_i),
         .rw_valid_i   (rw_valid_i),
         .rw_reg_i     (rw_reg_i),
         .ev_valid_i   (ev_valid_i),
         .ev_line_i    (ev_line_i),
         .sa_valid_i   (sa_valid_i),
         .sa_line_i    (sa_line_i),
         .valid_o      (ent_valid[g]),
         .hit_o        (ent_hit[g]),
         .dup_o        (ent_dup[g]),
         .data_o       (ent_data[g])
      );
   end

   always_comb begin
      lk_data_o = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (ent_hit[i]) lk_data_o = lk_data_o | ent_data[i];
      end
      lk_hit_o = |ent_hit;
   end

   // R2
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ent_hit));

   // R2
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit_o |-> (lk_data_o == '0));

   // R11
   flush_same_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !lk_hit_o);

   // R1
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && !fl_valid_i) |=> (ent_valid == '0));

   // R7
   fill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid_i && (flush_i || (rw_valid_i && rw_reg_i == fl_base_i) ||
                      (ev_valid_i && ev_line_i == fl_line_i) ||
                      (sa_valid_i && sa_line_i == fl_line_i))) |-> (ent_we == '0));

endmodule

// File: tb/sim_symtag_l0_cache.sv
module sim_symtag_l0_cache;
   localparam int RW = 4, SW = 2, DW = 32, LW = 9, XW = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          flush;
   logic          lk_v, lk_hx, fl_v, fl_hx, rw_v, ev_v, sa_v;
   logic [RW-1:0] lk_b, lk_x, fl_b, fl_x, rw_r;
   logic [SW-1:0] lk_s, fl_s;
   logic [DW-1:0] lk_d, fl_d;
   logic [LW-1:0] fl_l, ev_l, sa_l;
   logic [XW-1:0] fl_dat;
   logic          hit;
   logic [XW-1:0] dat;

   symtag_l0_cache u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .lk_valid_i(lk_v), .lk_base_i(lk_b), .lk_has_idx_i(lk_hx), .lk_idx_i(lk_x),
      .lk_scale_i(lk_s), .lk_disp_i(lk_d), .lk_hit_o(hit), .lk_data_o(dat),
      .fl_valid_i(fl_v), .fl_base_i(fl_b), .fl_has_idx_i(fl_hx), .fl_idx_i(fl_x),
      .fl_scale_i(fl_s), .fl_disp_i(fl_d), .fl_line_i(fl_l), .fl_data_i(fl_dat),
      .rw_valid_i(rw_v), .rw_reg_i(rw_r), .ev_valid_i(ev_v), .ev_line_i(ev_l),
      .sa_valid_i(sa_v), .sa_line_i(sa_l)
   );

   // behavioural reference state
   logic          m_v  [2];
   logic          m_hx [2];
   logic [RW-1:0] m_b  [2];
   logic [RW-1:0] m_x  [2];
   logic [SW-1:0] m_s  [2];
   logic [DW-1:0] m_d  [2];
   logic [LW-1:0] m_l  [2];
   logic [XW-1:0] m_dat[2];
   int            m_lru;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 0;

   function automatic bit tag_eq(int e, logic [RW-1:0] b, logic hx, logic [RW-1:0] x,
                                 logic [SW-1:0] s, logic [DW-1:0] d);
      if (b != m_b[e] || hx != m_hx[e] || d != m_d[e]) return 0;
      if (hx && (x != m_x[e] || s != m_s[e])) return 0;
      return 1;
   endfunction

   function automatic bit killed(int e);
      if (flush) return 1;
      if (!m_v[e]) return 0;
      if (rw_v && (rw_r == m_b[e] || (m_hx[e] && rw_r == m_x[e]))) return 1;
      if (ev_v && ev_l == m_l[e]) return 1;
      if (sa_v && sa_l == m_l[e]) return 1;
      return 0;
   endfunction

   function automatic int hit_way();
      for (int e = 0; e < 2; e++)
         if (lk_v && m_v[e] && !killed(e) && tag_eq(e, lk_b, lk_hx, lk_x, lk_s, lk_d)) return e;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < 2; e++) begin
            m_v[e] = 0; m_hx[e] = 0; m_b[e] = 0; m_x[e] = 0;
            m_s[e] = 0; m_d[e] = 0; m_l[e] = 0; m_dat[e] = 0;
         end
         m_lru = 0;
      end else begin
         int  hw, tgt;
         bit  kl[2];
         bit  go;
         hw = hit_way();
         for (int e = 0; e < 2; e++) kl[e] = killed(e);
         go = fl_v && !flush && !(rw_v && (rw_r == fl_b || (fl_hx && rw_r == fl_x))) &&
              !(ev_v && ev_l == fl_l) && !(sa_v && sa_l == fl_l);
         tgt = -1;
         for (int e = 0; e < 2; e++)
            if (tgt < 0 && m_v[e] && tag_eq(e, fl_b, fl_hx, fl_x, fl_s, fl_d)) tgt = e;
         for (int e = 0; e < 2; e++)
            if (tgt < 0 && !m_v[e]) tgt = e;
         if (tgt < 0) tgt = m_lru;
         for (int e = 0; e < 2; e++) begin
            if (go && tgt == e) begin
               m_v[e] = 1; m_hx[e] = fl_hx; m_b[e] = fl_b; m_x[e] = fl_x;
               m_s[e] = fl_s; m_d[e] = fl_d; m_l[e] = fl_l; m_dat[e] = fl_dat;
            end else if (kl[e]) m_v[e] = 0;
         end
         if (go) m_lru = 1 - tgt;
         else if (hw >= 0) m_lru = 1 - hw;
      end
   end

   task automatic clr();
      flush = 0; lk_v = 0; lk_hx = 0; lk_b = 0; lk_x = 0; lk_s = 0; lk_d = 0;
      fl_v = 0; fl_hx = 0; fl_b = 0; fl_x = 0; fl_s = 0; fl_d = 0; fl_l = 0; fl_dat = 0;
      rw_v = 0; rw_r = 0; ev_v = 0; ev_l = 0; sa_v = 0; sa_l = 0;
   endtask

   task automatic set_lk(int b, bit hx, int x, int s, int d);
      lk_v = 1; lk_b = RW'(b); lk_hx = hx; lk_x = RW'(x); lk_s = SW'(s); lk_d = DW'(d);
   endtask

   task automatic set_fl(int b, bit hx, int x, int s, int d, int l, logic [31:0] seed);
      fl_v = 1; fl_b = RW'(b); fl_hx = hx; fl_x = RW'(x); fl_s = SW'(s); fl_d = DW'(d);
      fl_l = LW'(l); fl_dat = {16{seed}};
   endtask

   // exp_hit: 0/1 directed expectation, -1 model only
   task automatic cyc(string req, int exp_hit);
      int            hw;
      logic          eh;
      logic [XW-1:0] ed;
      #2;
      hw = hit_way();
      eh = (hw >= 0);
      ed = (hw >= 0) ? m_dat[hw] : '0;
      checks++;
      if (hit !== eh || dat !== ed) begin
         errors++;
         $display("FAIL %s model: hit act=%0b exp=%0b data act=%h exp=%h", req, hit, eh, dat, ed);
      end
      if (exp_hit >= 0) begin
         checks++;
         if (hit !== exp_hit[0]) begin
            errors++;
            $display("FAIL %s directed: hit act=%0b exp=%0b", req, hit, exp_hit[0]);
         end
      end
      @(negedge clk);
      clr();
   endtask

   initial begin
      clr();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      set_lk(1, 1, 2, 1, 'h40); cyc("R1", 0);
      // R10 fill not visible in its own cycle
      set_fl(1, 1, 2, 1, 'h40, 5, 32'hA1A1_0001); set_lk(1, 1, 2, 1, 'h40); cyc("R10", 0);
      // R2 hit with data
      set_lk(1, 1, 2, 1, 'h40); cyc("R2", 1);
      set_lk(1, 1, 2, 1, 'h41); cyc("R2", 0);
      set_lk(1, 1, 2, 2, 'h40); cyc("R2", 0);
      // R3 no-index entry, idx/scale ignored
      set_fl(3, 0, 9, 3, 8, 9, 32'hB2B2_0002); cyc("R8", -1);
      set_lk(3, 0, 5, 0, 8); cyc("R3", 1);
      set_lk(3, 1, 5, 0, 8); cyc("R3", 0);
      // R8 LRU replacement
      set_lk(1, 1, 2, 1, 'h40); cyc("R8", 1);
      set_fl(4, 0, 7, 0, 16, 11, 32'hC3C3_0003); cyc("R8", -1);
      set_lk(3, 0, 9, 3, 8); cyc("R8", 0);
      set_lk(1, 1, 2, 1, 'h40); cyc("R8", 1);
      set_lk(4, 0, 0, 0, 16); cyc("R8", 1);
      // R4 index register write, same cycle and after
      rw_v = 1; rw_r = 2; set_lk(1, 1, 2, 1, 'h40); cyc("R4", 0);
      set_lk(1, 1, 2, 1, 'h40); cyc("R4", 0);
      // R3 write to idx field of no-index entry has no effect
      rw_v = 1; rw_r = 7; cyc("R3", -1);
      set_lk(4, 0, 0, 0, 16); cyc("R3", 1);
      // R4 base register write
      rw_v = 1; rw_r = 4; cyc("R4", -1);
      set_lk(4, 0, 0, 0, 16); cyc("R4", 0);
      // R5 eviction
      set_fl(1, 1, 2, 1, 'h40, 5, 32'hA1A1_0004); cyc("R8", -1);
      ev_v = 1; ev_l = 5; set_lk(1, 1, 2, 1, 'h40); cyc("R5", 0);
      set_lk(1, 1, 2, 1, 'h40); cyc("R5", 0);
      // R6 store alias
      set_fl(1, 1, 2, 1, 'h40, 5, 32'hA1A1_0005); cyc("R6", -1);
      set_lk(1, 1, 2, 1, 'h40); cyc("R6", 1);
      sa_v = 1; sa_l = 5; set_lk(1, 1, 2, 1, 'h40); cyc("R6", 0);
      set_lk(1, 1, 2, 1, 'h40); cyc("R6", 0);
      // R7 dropped fills
      set_fl(6, 0, 0, 0, 0, 12, 32'hD4D4_0006); rw_v = 1; rw_r = 6; cyc("R7", -1);
      set_lk(6, 0, 0, 0, 0); cyc("R7", 0);
      set_fl(6, 0, 0, 0, 0, 12, 32'hD4D4_0006); ev_v = 1; ev_l = 12; cyc("R7", -1);
      set_lk(6, 0, 0, 0, 0); cyc("R7", 0);
      set_fl(6, 0, 0, 0, 0, 12, 32'hD4D4_0006); sa_v = 1; sa_l = 12; cyc("R7", -1);
      set_lk(6, 0, 0, 0, 0); cyc("R7", 0);
      set_fl(6, 0, 0, 0, 0, 12, 32'hD4D4_0006); flush = 1; cyc("R7", -1);
      set_lk(6, 0, 0, 0, 0); cyc("R7", 0);
      set_fl(6, 0, 0, 0, 0, 12, 32'hD4D4_0006); rw_v = 1; rw_r = 8; cyc("R7", -1);
      set_lk(6, 0, 0, 0, 0); cyc("R7", 1);
      // R9 duplicate fill overwrites its own entry
      set_fl(1, 1, 2, 1, 'h40, 5, 32'hE5E5_0007); cyc("R9", -1);
      set_fl(1, 1, 2, 1, 'h40, 5, 32'hE5E5_0008); cyc("R9", -1);
      set_lk(6, 0, 0, 0, 0); cyc("R9", 1);
      set_lk(1, 1, 2, 1, 'h40); cyc("R9", 1);
      // R11 flush same cycle, R1 after flush
      flush = 1; set_lk(6, 0, 0, 0, 0); cyc("R11", 0);
      set_lk(6, 0, 0, 0, 0); cyc("R1", 0);
      set_lk(1, 1, 2, 1, 'h40); cyc("R1", 0);
      // mixed random traffic against the model
      for (int n = 0; n < 600; n++) begin
         lk_v = 1'($urandom); lk_b = RW'($urandom % 4); lk_hx = 1'($urandom);
         lk_x = RW'($urandom % 4); lk_s = SW'($urandom % 2); lk_d = DW'($urandom % 2);
         fl_v = 1'($urandom); fl_b = RW'($urandom % 4); fl_hx = 1'($urandom);
         fl_x = RW'($urandom % 4); fl_s = SW'($urandom % 2); fl_d = DW'($urandom % 2);
         fl_l = LW'($urandom % 4); fl_dat = {16{$urandom}};
         rw_v = (($urandom % 4) == 0); rw_r = RW'($urandom % 6);
         ev_v = (($urandom % 5) == 0); ev_l = LW'($urandom % 4);
         sa_v = (($urandom % 6) == 0); sa_l = LW'($urandom % 4);
         flush = (($urandom % 32) == 0);
         cyc("R2", -1);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1: act=timeout exp=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule